// File: doc/BRIEF.md
# EEPROM Status Register Write Guard

This block keeps the status register of a small serial EEPROM and rules on every write the device is asked to perform. It receives instruction strobes that have already been decoded from the serial stream. These are latch set and clear, flag set and clear, a status write carrying a data byte, and an array write carrying a 12-bit address. It also receives a hardware protect pin and a busy indication from the nonvolatile write engine. For each write request it answers, in the same cycle, with either a grant or a deny. At all times it presents the register as a byte for the read path.

Array writes are refused inside the region selected by two lock bits. Status writes are refused while the protect pin is low and the protect-enable bit is set. Because of this, a board that ties the pin low can still program the register once, and only up to the moment protect-enable is set. A granted write is held pending. It is committed when the busy indication falls. A pin change during that time therefore cannot cancel a status write that has already been accepted. The nonvolatile bits are plain registers that power-up reset leaves untouched. Their power-on contents come from a parameter.

Top module: `eeprom_sr_guard`

## Requirements
- R1: A latch-set strobe makes the write-enable bit 1 after the next clock edge, and a latch-clear strobe makes it 0. Clear wins if both strobes arrive together.
- R2: A flag-set strobe makes the flag bit 1 after the next edge, and a flag-clear strobe makes it 0. Clear wins if both arrive together.
- R3: While rst_n is low at a clock edge, the write-enable bit, the flag and any pending write are cleared. The protect-enable and lock bits keep their values.
- R4: The lock field selects the refused array addresses. Value 0 refuses none. Value 1 refuses 0xC00 to 0xFFF. Value 2 refuses 0x800 to 0xFFF. Value 3 refuses every address.
- R5: An array write is granted only if the write-enable bit is 1 and its address lies outside the locked range.
- R6: A status write is granted only if the write-enable bit is 1 and either the protect pin is high or protect-enable is 0. On commit, data bit 7 becomes protect-enable and data bits 3:2 become the lock field. The other data bits have no effect.
- R7: A granted write stays pending until wr_busy has been high at one or more edges and is then low at an edge. At that edge a pending status write updates its bits, and the write-enable bit clears for either kind of write.
- R8: A status write that was already granted commits even if the protect pin goes low while it is pending and protect-enable is 1.
- R9: While wr_busy is high or a write is pending, every write request is denied. The status byte still reflects the current state.
- R10: The status byte carries protect-enable at bit 7, the lock field at bits 3:2, write-enable at bit 1 and the flag at bit 0. Bits 6:4 read 0.
- R11: Each array or status write request raises exactly one of its grant and deny outputs in the same cycle. With no request, both outputs stay low.
- R12: Once protect-enable has been committed as 1 while the pin is low, status writes are denied until the pin is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| cmd_wren | input | 1 | Set write-enable latch strobe |
| cmd_wrds | input | 1 | Clear write-enable latch strobe |
| cmd_sflb | input | 1 | Set flag strobe |
| cmd_rflb | input | 1 | Clear flag strobe |
| cmd_wrsr | input | 1 | Status write request |
| wrsr_data | input | 8 | Data byte of the status write |
| cmd_awr | input | 1 | Array write request |
| awr_addr | input | 12 | Address of the array write |
| unlock_pin | input | 1 | Hardware protect pin; low means protected |
| wr_busy | input | 1 | Nonvolatile write engine busy |
| status_byte | output | 8 | Register read value |
| awr_grant | output | 1 | Array write accepted |
| awr_deny | output | 1 | Array write refused |
| sr_grant | output | 1 | Status write accepted |
| sr_deny | output | 1 | Status write refused |

## Verification
Every bit of the register appears on status_byte, so a wrong write-enable, flag, lock or protect-enable value can be seen on the first cycle after the edge that corrupted it. A decision built on stale or wrong state shows up as a swapped grant or deny in the very cycle of the request. A pending flag that failed to clear would deny the next write, which is also visible in that cycle. Random command sequences are compared against a model held in the bench. Directed cases cover every lock boundary address, the one-time lock sequence, and a pin drop while a status write is in flight.

// File: rtl/sr_guard_pkg.sv
// Shared types of the status register guard.
// Assumes a single nonvolatile group made of protect-enable and a 2-bit lock field.
package sr_guard_pkg;

    typedef struct packed {
        logic       wpen;
        logic [1:0] lock;
    } nv_bits_t;

    typedef enum logic [1:0] {
        PEND_NONE   = 2'd0,
        PEND_ARRAY  = 2'd1,
        PEND_STATUS = 2'd2
    } pend_kind_t;

endpackage

// File: rtl/sr_lock_decode.sv
// Decides whether an array address falls inside the locked region.
// Assumes the region is always a top-aligned power-of-two share of the
// array: none, the top quarter, the top half or all of it.
module sr_lock_decode #(
    parameter int ADDR_W = 12
) (
    input  logic [1:0]        lock,
    input  logic [ADDR_W-1:0] addr,
    output logic              locked
);
    localparam int TOP = ADDR_W - 1;

    // Compare the two top address bits against the selected share.
    always_comb begin
        unique case (lock)
            2'b00:   locked = 1'b0;
            2'b01:   locked = addr[TOP] & addr[TOP-1];
            2'b10:   locked = addr[TOP];
            default: locked = 1'b1;
        endcase
    end
endmodule

// File: rtl/sr_wp_interlock.sv
// Decides whether the status register may be written under the pin rule.
// Assumes the pin is already synchronised to clk.
module sr_wp_interlock (
    input  logic wpen,
    input  logic pin_high,
    output logic sr_allowed
);
    // Writes are blocked only when protect-enable is set and the pin is low.
    always_comb sr_allowed = pin_high | ~wpen;
endmodule

// File: rtl/sr_state.sv
// Holds the volatile latch and flag, the nonvolatile bits and the pending
// write. A write commits when busy falls after it was high at one or more
// edges. The nonvolatile bits ignore reset and power on as NV_INIT.
module sr_state
    import sr_guard_pkg::*;
#(
    parameter nv_bits_t NV_INIT = '0
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     set_wel,
    input  logic     clr_wel,
    input  logic     set_flag,
    input  logic     clr_flag,
    input  logic     start_status,
    input  logic     start_array,
    input  nv_bits_t new_nv,
    input  logic     wr_busy,
    output logic     wel,
    output logic     flag,
    output nv_bits_t nv,
    output logic     pend_any
);
    pend_kind_t pend_q;
    nv_bits_t   pend_nv_q;
    nv_bits_t   nv_q = NV_INIT;
    logic       busy_d;
    logic       finish;

    assign finish   = (pend_q != PEND_NONE) && busy_d && !wr_busy;
    assign pend_any = (pend_q != PEND_NONE);
    assign nv       = nv_q;

    // Remember the busy level of the previous cycle to find its fall.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_d <= 1'b0;
        else        busy_d <= wr_busy;
    end

    // Write-enable latch: a clear or a finished write wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)                  wel <= 1'b0;
        else if (finish || clr_wel)  wel <= 1'b0;
        else if (set_wel)            wel <= 1'b1;
    end

    // Flag latch: a clear wins over a set.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag <= 1'b0;
        else if (clr_flag) flag <= 1'b0;
        else if (set_flag) flag <= 1'b1;
    end

    // Track which kind of granted write is waiting for busy to fall.
    always_ff @(posedge clk) begin
        if (!rst_n)            pend_q <= PEND_NONE;
        else if (finish)       pend_q <= PEND_NONE;
        else if (start_status) pend_q <= PEND_STATUS;
        else if (start_array)  pend_q <= PEND_ARRAY;
    end

    // Capture the new nonvolatile value when a status write is granted.
    always_ff @(posedge clk) begin
        if (start_status) pend_nv_q <= new_nv;
    end

    // Commit the nonvolatile bits; reset leaves them untouched.
    always_ff @(posedge clk) begin
        if (rst_n && finish && (pend_q == PEND_STATUS)) nv_q <= pend_nv_q;
    end
endmodule

// File: rtl/eeprom_sr_guard.sv
// Top of the status register guard. Grants or denies array and status
// writes in the cycle of the request and builds the read byte.
// Assumes the strobes are single-cycle pulses from the instruction decoder.
module eeprom_sr_guard
    import sr_guard_pkg::*;
#(
    parameter int       ADDR_W  = 12,
    parameter int       BYTE_W  = 8,
    parameter nv_bits_t NV_INIT = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wren,
    input  logic              cmd_wrds,
    input  logic              cmd_sflb,
    input  logic              cmd_rflb,
    input  logic              cmd_wrsr,
    input  logic [BYTE_W-1:0] wrsr_data,
    input  logic              cmd_awr,
    input  logic [ADDR_W-1:0] awr_addr,
    input  logic              unlock_pin,
    input  logic              wr_busy,
    output logic [BYTE_W-1:0] status_byte,
    output logic              awr_grant,
    output logic              awr_deny,
    output logic              sr_grant,
    output logic              sr_deny
);
    localparam int BIT_WPEN = BYTE_W - 1;
    localparam int BIT_LOCK = 2;
    localparam int BIT_WEL  = 1;
    localparam int BIT_FLAG = 0;

    logic     wel, flag, pend_any, locked, sr_allowed, may_write;
    nv_bits_t nv, new_nv;

    sr_lock_decode #(.ADDR_W(ADDR_W)) u_lock (
        .lock   (nv.lock),
        .addr   (awr_addr),
        .locked (locked)
    );

    sr_wp_interlock u_wp (
        .wpen       (nv.wpen),
        .pin_high   (unlock_pin),
        .sr_allowed (sr_allowed)
    );

    // Common gate: latch set, engine idle, nothing waiting to commit.
    always_comb may_write = wel && !wr_busy && !pend_any;

    // Per-request decisions; exactly one answer per request.
    always_comb begin
        awr_grant = cmd_awr && may_write && !locked;
        awr_deny  = cmd_awr && !awr_grant;
        sr_grant  = cmd_wrsr && may_write && sr_allowed;
        sr_deny   = cmd_wrsr && !sr_grant;
    end

    // Select the register fields carried by a status write.
    always_comb begin
        new_nv.wpen = wrsr_data[BIT_WPEN];
        new_nv.lock = wrsr_data[BIT_LOCK+1:BIT_LOCK];
    end

    sr_state #(.NV_INIT(NV_INIT)) u_state (
        .clk          (clk),
        .rst_n        (rst_n),
        .set_wel      (cmd_wren),
        .clr_wel      (cmd_wrds),
        .set_flag     (cmd_sflb),
        .clr_flag     (cmd_rflb),
        .start_status (sr_grant),
        .start_array  (awr_grant),
        .new_nv       (new_nv),
        .wr_busy      (wr_busy),
        .wel          (wel),
        .flag         (flag),
        .nv           (nv),
        .pend_any     (pend_any)
    );

    // Assemble the read byte; unused positions read zero.
    always_comb begin
        status_byte                          = '0;
        status_byte[BIT_WPEN]                = nv.wpen;
        status_byte[BIT_LOCK+1:BIT_LOCK]     = nv.lock;
        status_byte[BIT_WEL]                 = wel;
        status_byte[BIT_FLAG]                = flag;
    end
endmodule

// File: rtl/sr_guard_chk.sv
// Property checker for eeprom_sr_guard, attached with bind.
// Assumes the default parameters: an 8-bit byte and a 12-bit address.
module sr_guard_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_sflb,
    input logic        cmd_rflb,
    input logic        cmd_wrsr,
    input logic        cmd_awr,
    input logic        unlock_pin,
    input logic        wr_busy,
    input logic [7:0]  status_byte,
    input logic        awr_grant,
    input logic        awr_deny,
    input logic        sr_grant,
    input logic        sr_deny
);
    assert_awr_needs_wel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        awr_grant |-> status_byte[1]);

    assert_sr_needs_wel_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sr_grant |-> status_byte[1]);

    assert_busy_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_busy |-> (!sr_grant && !awr_grant));

    assert_pin_lock_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wrsr && !unlock_pin && status_byte[7]) |-> !sr_grant);

    assert_full_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_awr && status_byte[3:2] == 2'b11) |-> !awr_grant);

    assert_awr_one_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_awr |-> (awr_grant != awr_deny));

    assert_sr_one_answer_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wrsr |-> (sr_grant != sr_deny));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_awr && !cmd_wrsr) |-> !(awr_grant || awr_deny || sr_grant || sr_deny));

    assert_flag_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_sflb && !cmd_rflb) |=> status_byte[0]);

    assert_unused_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_byte[6:4] == 3'b000);

    assert_nv_moves_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ({status_byte[7], status_byte[3:2]} != $past({status_byte[7], status_byte[3:2]}))
            |-> $past(!wr_busy));
endmodule

bind eeprom_sr_guard sr_guard_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_sflb    (cmd_sflb),
    .cmd_rflb    (cmd_rflb),
    .cmd_wrsr    (cmd_wrsr),
    .cmd_awr     (cmd_awr),
    .unlock_pin  (unlock_pin),
    .wr_busy     (wr_busy),
    .status_byte (status_byte),
    .awr_grant   (awr_grant),
    .awr_deny    (awr_deny),
    .sr_grant    (sr_grant),
    .sr_deny     (sr_deny)
);

// File: tb/eeprom_sr_guard_tb_top.sv
// Self-checking bench: seeded random commands plus directed corner cases,
// compared against a behavioural model kept in bench variables.
module eeprom_sr_guard_tb_top;
    localparam int OP_WREN = 0, OP_WRDS = 1, OP_SFLB = 2, OP_RFLB = 3,
                   OP_WRSR = 4, OP_AWR = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_wren = 0, cmd_wrds = 0, cmd_sflb = 0, cmd_rflb = 0;
    logic        cmd_wrsr = 0, cmd_awr = 0;
    logic [7:0]  wrsr_data = '0;
    logic [11:0] awr_addr = '0;
    logic        unlock_pin = 1'b1;
    logic        wr_busy = 1'b0;
    logic [7:0]  status_byte;
    logic        awr_grant, awr_deny, sr_grant, sr_deny;

    int total = 0;
    int bad   = 0;

    // model state
    bit       e_wel = 0, e_flag = 0, e_wpen = 0, e_pend = 0, e_pstat = 0;
    bit [1:0] e_lock = 2'b00;
    bit [7:0] e_pdata = '0;

    always #5 clk = ~clk;

    eeprom_sr_guard dut_i (
        .clk(clk), .rst_n(rst_n),
        .cmd_wren(cmd_wren), .cmd_wrds(cmd_wrds), .cmd_sflb(cmd_sflb), .cmd_rflb(cmd_rflb),
        .cmd_wrsr(cmd_wrsr), .wrsr_data(wrsr_data), .cmd_awr(cmd_awr), .awr_addr(awr_addr),
        .unlock_pin(unlock_pin), .wr_busy(wr_busy), .status_byte(status_byte),
        .awr_grant(awr_grant), .awr_deny(awr_deny), .sr_grant(sr_grant), .sr_deny(sr_deny)
    );

    function automatic bit exp_locked(input bit [1:0] lk, input bit [11:0] a);
        case (lk)
            2'b00:   return 1'b0;
            2'b01:   return a >= 12'hC00;
            2'b10:   return a >= 12'h800;
            default: return 1'b1;
        endcase
    endfunction

    function automatic bit [7:0] exp_byte();
        return {e_wpen, 3'b000, e_lock, e_wel, e_flag};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_cmds();
        cmd_wren = 0; cmd_wrds = 0; cmd_sflb = 0; cmd_rflb = 0;
        cmd_wrsr = 0; cmd_awr = 0;
    endtask

    // Let a granted write run: busy for n cycles, optional pin flip, then fall.
    task automatic finish_write(input int n, input bit flip);
        wr_busy = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (i == 0) begin
                if (flip) unlock_pin = ~unlock_pin;
                cmd_wrsr = 1; cmd_awr = 1; awr_addr = 12'h000;
                #1;
                chk(sr_deny && !sr_grant && awr_deny && !awr_grant, "R9",
                    {sr_grant, sr_deny, awr_grant, awr_deny}, 4'b0101);
                chk(status_byte == exp_byte(), "R9", status_byte, exp_byte());
                #1; clear_cmds();
            end
        end
        wr_busy = 1'b0;
        @(posedge clk); #1;
        if (e_pstat) begin
            e_wpen = e_pdata[7];
            e_lock = e_pdata[3:2];
        end
        e_wel = 0; e_pend = 0;
        chk(status_byte == exp_byte(), (flip && e_pstat) ? "R8" : "R7",
            status_byte, exp_byte());
    endtask

    // Issue one command, check the same-cycle answer and the byte after the edge.
    task automatic issue(input int op, input bit [11:0] a, input bit [7:0] d,
                         input string tag, input int nbusy, input bit flip);
        bit g;
        g = 0;
        @(negedge clk);
        case (op)
            OP_WREN: cmd_wren = 1;
            OP_WRDS: cmd_wrds = 1;
            OP_SFLB: cmd_sflb = 1;
            OP_RFLB: cmd_rflb = 1;
            OP_WRSR: begin cmd_wrsr = 1; wrsr_data = d; end
            default: begin cmd_awr = 1; awr_addr = a; end
        endcase
        #2;
        if (op == OP_WRSR) begin
            g = e_wel && (unlock_pin || !e_wpen);
            chk(sr_grant == g && sr_deny == !g && !awr_grant && !awr_deny, tag,
                {sr_grant, sr_deny}, {g, !g});
        end else if (op == OP_AWR) begin
            g = e_wel && !exp_locked(e_lock, a);
            chk(awr_grant == g && awr_deny == !g && !sr_grant && !sr_deny, tag,
                {awr_grant, awr_deny}, {g, !g});
        end else begin
            chk(!(awr_grant || awr_deny || sr_grant || sr_deny), "R11",
                {awr_grant, awr_deny, sr_grant, sr_deny}, 0);
        end
        @(posedge clk); #1;
        clear_cmds();
        case (op)
            OP_WREN: e_wel = 1;
            OP_WRDS: e_wel = 0;
            OP_SFLB: e_flag = 1;
            OP_RFLB: e_flag = 0;
            OP_WRSR: if (g) begin e_pend = 1; e_pstat = 1; e_pdata = d; end
            default: if (g) begin e_pend = 1; e_pstat = 0; end
        endcase
        chk(status_byte == exp_byte(), (op < OP_WRSR) ? "R1 R2 R10" : "R10",
            status_byte, exp_byte());
        if (e_pend) finish_write(nbusy, flip);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 0;
        @(posedge clk); #1; rst_n = 1;
        e_wel = 0; e_flag = 0; e_pend = 0;
        chk(status_byte == exp_byte(), "R3", status_byte, exp_byte());
    endtask

    // watchdog
    initial begin
        #2_000_000;
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_c0de));
        @(posedge clk); #1; rst_n = 1;
        chk(status_byte == 8'h00, "R3", status_byte, 0);

        // R1/R2 set and clear
        issue(OP_SFLB, 0, 0, "R2", 1, 0);
        issue(OP_RFLB, 0, 0, "R2", 1, 0);
        issue(OP_AWR, 12'h123, 0, "R5", 1, 0);          // no latch: denied
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRDS, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h04, "R6", 1, 0);           // no latch: denied

        // R4: each lock value at its boundary addresses
        for (int lk = 1; lk < 4; lk++) begin
            issue(OP_WREN, 0, 0, "R1", 1, 0);
            issue(OP_WRSR, 0, 8'h73 | 8'(lk << 2), "R6", 2, 0);  // bits 6:4,1:0 ignored
            issue(OP_WREN, 0, 0, "R1", 1, 0); issue(OP_AWR, 12'hBFF, 0, "R4", 1, 0);
            issue(OP_WREN, 0, 0, "R1", 1, 0); issue(OP_AWR, 12'hC00, 0, "R4", 1, 0);
            issue(OP_WREN, 0, 0, "R1", 1, 0); issue(OP_AWR, 12'h7FF, 0, "R4", 1, 0);
            issue(OP_WREN, 0, 0, "R1", 1, 0); issue(OP_AWR, 12'h800, 0, "R4", 1, 0);
            issue(OP_WREN, 0, 0, "R1", 1, 0); issue(OP_AWR, 12'h000, 0, "R4", 1, 0);
            issue(OP_WRDS, 0, 0, "R1", 1, 0);
        end

        // R3: reset keeps nonvolatile bits
        issue(OP_SFLB, 0, 0, "R2", 1, 0);
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        do_reset();

        // R12: program with pin low, set protect-enable, then locked out
        unlock_pin = 0;
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h84, "R12", 3, 0);
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h00, "R12", 1, 0);
        unlock_pin = 1;
        issue(OP_WRSR, 0, 8'h00, "R12", 2, 0);

        // R8: pin drops while a status write with protect-enable set is pending
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h88, "R6", 2, 0);
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h8C, "R8", 3, 1);           // pin now low
        issue(OP_WREN, 0, 0, "R1", 1, 0);
        issue(OP_WRSR, 0, 8'h00, "R12", 1, 0);
        unlock_pin = 1;

        // random mix
        for (int k = 0; k < 400; k++) begin
            int r;
            r = $urandom % 11;
            if (r < 3)       issue(OP_WREN, 0, 0, "R1", 1, 0);
            else if (r == 3) issue(OP_WRDS, 0, 0, "R1", 1, 0);
            else if (r == 4) issue(OP_SFLB, 0, 0, "R2", 1, 0);
            else if (r == 5) issue(OP_RFLB, 0, 0, "R2", 1, 0);
            else if (r < 8)  issue(OP_WRSR, 0, 8'($urandom), "R6", 1 + $urandom % 4, 1'($urandom));
            else if (r < 10) issue(OP_AWR, 12'($urandom), 0, "R5", 1 + $urandom % 3, 1'($urandom));
            else             unlock_pin = 1'($urandom);
            if (k == 200) do_reset();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule